// File: doc/BRIEF.md
# Glitch-Free Clock Stop and Power-Down Gate

This block sits after the clock dividers of a clock generator. It turns a set of free-running internal clocks into gated output clocks. Three asynchronous active-low controls can force groups of outputs LOW: a power-down request, a CPU-clock halt and a PCI-clock halt. A per-output enable word from the configuration registers can also hold any single output LOW. Every output stops and restarts only while its source clock is LOW, so no output ever shows a shortened high or low phase.

All control decisions are taken on rising edges of the CPU clock. Each control input first passes through a two-flop synchronizer. A small state machine qualifies the power-down request. It has three states: `PD_RUN` (normal operation), `PD_ARM` (the request has been seen LOW once) and `PD_DOWN` (every output held LOW). It has four transitions. *arm* goes from `PD_RUN` to `PD_ARM` when the synchronized request is LOW. *commit* goes from `PD_ARM` to `PD_DOWN` when the request is still LOW. *abort* goes from `PD_ARM` back to `PD_RUN` when the request has returned HIGH. *wake* goes from `PD_DOWN` to `PD_RUN` when the request is HIGH. The state machine and the halt controls together form one request bit per output. A cell clocked on the falling edge of that output's source clock captures the bit and gates the output.

Top module: `clk_stop_gate`

## Requirements
- R1: While `rst_n` is LOW, every gated output is LOW.
- R2: Each of `pwrdn_n`, `cpu_halt_n` and `pci_halt_n` passes through a two-flop synchronizer clocked by `clk_cpu`. If `cpu_halt_n` falls just after rising edge E0, the CPU output still has its high phase after E2, and it has no high phase after E3.
- R3: Power-down starts only after the synchronized request has been LOW on two consecutive `clk_cpu` rising edges. A `pwrdn_n` pulse LOW for one CPU cycle never stops an output. A pulse LOW for two CPU cycles stops the outputs for exactly one CPU cycle.
- R4: When power-down is committed at rising edge E, the CPU outputs keep the full high phase that starts at E and are LOW from the following falling edge on. In power-down, every output is LOW.
- R5: `cpu_halt_n` LOW stops only `cpu_clk_o`, which stays LOW. `cpuf_clk_o` keeps toggling.
- R6: `pci_halt_n` LOW stops `pci_clk_o[5:0]`, which stay LOW. `pcif_clk_o` and all other outputs keep toggling.
- R7: An output whose bit in `cfg_en` is 0 stays LOW. The bit map is: bit 0 `cpu_clk_o`, bit 1 `cpuf_clk_o`, bit 2 `pcif_clk_o`, bits 3..8 `pci_clk_o[0..5]`, bits 9..12 `aux_clk_o[0..3]`.
- R8: Every high pulse on an output is exactly one high phase of its source clock. Every low gap between two high pulses is at least one low phase of its source clock.
- R9: When `pwrdn_n` is released just after rising edge E0, the CPU output is still LOW after E3 and rises again at E4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_cpu | input | 1 | Free-running CPU clock; the reference for all decisions and the source of the two CPU outputs |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_pci | input | 1 | Free-running PCI clock, derived from the same PLL as clk_cpu |
| clk_aux | input | NAUX | Free-running sources of the other outputs |
| pwrdn_n | input | 1 | Asynchronous active-low power-down request |
| cpu_halt_n | input | 1 | Asynchronous active-low halt of the main CPU output |
| pci_halt_n | input | 1 | Asynchronous active-low halt of the stoppable PCI outputs |
| cfg_en | input | NOUT | Per-output enable bits from the configuration registers (map in R7) |
| cpu_clk_o | output | 1 | Stoppable CPU clock |
| cpuf_clk_o | output | 1 | Free-running CPU clock |
| pcif_clk_o | output | 1 | Free-running PCI clock |
| pci_clk_o | output | NPCI | Stoppable PCI clocks |
| aux_clk_o | output | NAUX | Other gated clocks |

## Verification
On every CPU falling edge, the assertions check four things. The state machine never jumps from running straight to power-down. Both CPU outputs are LOW once power-down has held for a sample. A disabled or halted CPU output stays LOW. The free-running CPU output stays high while nothing stops it. Other behaviour needs the bench's scenarios. This covers the exact edges at which the outputs stop and restart, the rejection of a one-cycle power-down pulse and the stop caused by a two-cycle pulse. It also covers which groups of outputs keep toggling under each mix of controls and enable words, and the pulse-width monitors that catch any runt on the slower PCI and auxiliary outputs.

// File: rtl/clkgate_pkg.sv
package clkgate_pkg;

    typedef enum logic [1:0] {
        PD_RUN  = 2'd0,
        PD_ARM  = 2'd1,
        PD_DOWN = 2'd2
    } pd_state_t;

    localparam int IDX_CPU  = 0;
    localparam int IDX_CPUF = 1;
    localparam int IDX_PCIF = 2;
    localparam int PCI_BASE = 3;

endpackage

// File: rtl/cg_sync.sv
module cg_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] stg [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stg[s] <= '1;
                end else if (s == 0) begin
                    stg[s] <= d_async;
                end else begin
                    stg[s] <= stg[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign q_sync = stg[STAGES-1];
endmodule

// File: rtl/cg_pd_fsm.sv
module cg_pd_fsm
    import clkgate_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      pd_req_n,
    output pd_state_t state,
    output logic      pd_down
);
    pd_state_t nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= PD_RUN;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            PD_RUN:  if (!pd_req_n) nxt = PD_ARM;
            PD_ARM:  nxt = pd_req_n ? PD_RUN : PD_DOWN;
            PD_DOWN: if (pd_req_n) nxt = PD_RUN;
            default: nxt = PD_RUN;
        endcase
    end

    always_comb begin
        pd_down = (state == PD_DOWN);
    end
endmodule

// File: rtl/cg_gate_cell.sv
module cg_gate_cell (
    input  logic src_clk,
    input  logic rst_n,
    input  logic run_req,
    output logic gclk
);
    logic en_q;

    always_ff @(negedge src_clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else begin
            en_q <= run_req;
        end
    end

    assign gclk = src_clk & en_q;
endmodule

// File: rtl/clk_stop_gate.sv
module clk_stop_gate
    import clkgate_pkg::*;
#(
    parameter  int NPCI        = 6,
    parameter  int NAUX        = 4,
    parameter  int SYNC_STAGES = 2,
    localparam int NOUT        = PCI_BASE + NPCI + NAUX
) (
    input  logic            clk_cpu,
    input  logic            rst_n,
    input  logic            clk_pci,
    input  logic [NAUX-1:0] clk_aux,
    input  logic            pwrdn_n,
    input  logic            cpu_halt_n,
    input  logic            pci_halt_n,
    input  logic [NOUT-1:0] cfg_en,
    output logic            cpu_clk_o,
    output logic            cpuf_clk_o,
    output logic            pcif_clk_o,
    output logic [NPCI-1:0] pci_clk_o,
    output logic [NAUX-1:0] aux_clk_o
);
    logic [2:0]      ctl_s;
    logic            pd_req_s;
    logic            cpu_run_s;
    logic            pci_run_s;
    pd_state_t       fsm_st;
    logic            pd_down;
    logic [NOUT-1:0] src_v;
    logic [NOUT-1:0] req_v;
    logic [NOUT-1:0] gclk_v;

    cg_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk_cpu),
        .rst_n   (rst_n),
        .d_async ({pci_halt_n, cpu_halt_n, pwrdn_n}),
        .q_sync  (ctl_s)
    );

    assign pd_req_s  = ctl_s[0];
    assign cpu_run_s = ctl_s[1];
    assign pci_run_s = ctl_s[2];

    cg_pd_fsm u_fsm (
        .clk      (clk_cpu),
        .rst_n    (rst_n),
        .pd_req_n (pd_req_s),
        .state    (fsm_st),
        .pd_down  (pd_down)
    );

    always_comb begin
        req_v = cfg_en & {NOUT{~pd_down}};
        req_v[IDX_CPU] = req_v[IDX_CPU] & cpu_run_s;
        for (int i = 0; i < NPCI; i++) begin
            req_v[PCI_BASE+i] = req_v[PCI_BASE+i] & pci_run_s;
        end
    end

    assign src_v = {clk_aux, {NPCI{clk_pci}}, clk_pci, clk_cpu, clk_cpu};

    generate
        for (genvar g = 0; g < NOUT; g++) begin : g_gate
            cg_gate_cell u_cell (
                .src_clk (src_v[g]),
                .rst_n   (rst_n),
                .run_req (req_v[g]),
                .gclk    (gclk_v[g])
            );
        end
    endgenerate

    assign cpu_clk_o  = gclk_v[IDX_CPU];
    assign cpuf_clk_o = gclk_v[IDX_CPUF];
    assign pcif_clk_o = gclk_v[IDX_PCIF];
    assign pci_clk_o  = gclk_v[PCI_BASE +: NPCI];
    assign aux_clk_o  = gclk_v[PCI_BASE+NPCI +: NAUX];
endmodule

// File: rtl/clk_stop_gate_chk.sv
module clk_stop_gate_chk
    import clkgate_pkg::*;
#(
    parameter int NOUT = 13
) (
    input logic            clk_cpu,
    input logic            rst_n,
    input logic [NOUT-1:0] cfg_en,
    input pd_state_t       st,
    input logic            cpu_run_s,
    input logic            cpu_clk_o,
    input logic            cpuf_clk_o
);
    // R3
    arm_before_down_chk: assert property (@(negedge clk_cpu) disable iff (!rst_n)
        ($past(st) == PD_RUN) |-> (st != PD_DOWN));

    // R4
    down_cpu_low_chk: assert property (@(negedge clk_cpu) disable iff (!rst_n)
        ($past(st) == PD_DOWN) |-> (!cpu_clk_o && !cpuf_clk_o));

    // R7
    en_off_low_chk: assert property (@(negedge clk_cpu) disable iff (!rst_n)
        (!$past(cfg_en[IDX_CPU])) |-> !cpu_clk_o);

    // R5
    halt_cpu_low_chk: assert property (@(negedge clk_cpu) disable iff (!rst_n)
        (!$past(cpu_run_s)) |-> !cpu_clk_o);

    // R5
    cpuf_free_chk: assert property (@(negedge clk_cpu) disable iff (!rst_n)
        ($past(rst_n) && $past(cfg_en[IDX_CPUF]) && ($past(st) != PD_DOWN))
            |-> cpuf_clk_o);
endmodule

bind clk_stop_gate clk_stop_gate_chk #(.NOUT(NOUT)) chk_i (
    .clk_cpu    (clk_cpu),
    .rst_n      (rst_n),
    .cfg_en     (cfg_en),
    .st         (fsm_st),
    .cpu_run_s  (cpu_run_s),
    .cpu_clk_o  (cpu_clk_o),
    .cpuf_clk_o (cpuf_clk_o)
);

// File: tb/clk_stop_gate_tb_top.sv
`timescale 1ns/1ps
module clk_stop_gate_tb_top;
    localparam int NPCI = 6;
    localparam int NAUX = 4;
    localparam int NOUT = 3 + NPCI + NAUX;
    localparam logic [NOUT-1:0] ALL = '1;

    logic            clk_cpu = 1'b0;
    logic            rst_n   = 1'b1;
    logic [3:0]      div     = '0;
    logic            clk_pci;
    logic [NAUX-1:0] clk_aux;
    logic            pwrdn_n    = 1'b1;
    logic            cpu_halt_n = 1'b1;
    logic            pci_halt_n = 1'b1;
    logic [NOUT-1:0] cfg_en     = '1;
    logic            cpu_clk_o, cpuf_clk_o, pcif_clk_o;
    logic [NPCI-1:0] pci_clk_o;
    logic [NAUX-1:0] aux_clk_o;
    logic [NOUT-1:0] obs;

    int n_tests = 0;
    int n_fail  = 0;
    bit mon_on  = 1'b0;
    int runts_cpu = 0, runts_cpuf = 0, runts_pci = 0, runts_aux = 0;
    int rise_cnt [NOUT];

    always #5 clk_cpu = ~clk_cpu;
    always @(posedge clk_cpu) div <= div + 4'd1;
    assign #1 clk_pci = div[0];
    assign #1 clk_aux = {NAUX{div[1]}};

    clk_stop_gate #(.NPCI(NPCI), .NAUX(NAUX)) dut_i (
        .clk_cpu    (clk_cpu),
        .rst_n      (rst_n),
        .clk_pci    (clk_pci),
        .clk_aux    (clk_aux),
        .pwrdn_n    (pwrdn_n),
        .cpu_halt_n (cpu_halt_n),
        .pci_halt_n (pci_halt_n),
        .cfg_en     (cfg_en),
        .cpu_clk_o  (cpu_clk_o),
        .cpuf_clk_o (cpuf_clk_o),
        .pcif_clk_o (pcif_clk_o),
        .pci_clk_o  (pci_clk_o),
        .aux_clk_o  (aux_clk_o)
    );

    assign obs = {aux_clk_o, pci_clk_o, pcif_clk_o, cpuf_clk_o, cpu_clk_o};

    for (genvar g = 0; g < NOUT; g++) begin : g_cnt
        initial rise_cnt[g] = 0;
        always @(posedge obs[g]) if (mon_on) rise_cnt[g] = rise_cnt[g] + 1;
    end

    // R8 pulse-width monitors: high = one source high phase, low >= one low phase
    real cr = -1.0, cf = -1.0, fr = -1.0, ff = -1.0;
    real pr = -1.0, pf = -1.0, ar = -1.0, af = -1.0;
    always @(posedge cpu_clk_o) if (mon_on) begin
        if (cf >= 0.0 && ($realtime - cf) < 4.99) runts_cpu++;
        cr = $realtime;
    end
    always @(negedge cpu_clk_o) if (mon_on && cr >= 0.0) begin
        if (($realtime - cr) < 4.99 || ($realtime - cr) > 5.01) runts_cpu++;
        cf = $realtime;
    end
    always @(posedge cpuf_clk_o) if (mon_on) begin
        if (ff >= 0.0 && ($realtime - ff) < 4.99) runts_cpuf++;
        fr = $realtime;
    end
    always @(negedge cpuf_clk_o) if (mon_on && fr >= 0.0) begin
        if (($realtime - fr) < 4.99 || ($realtime - fr) > 5.01) runts_cpuf++;
        ff = $realtime;
    end
    always @(posedge pci_clk_o[0]) if (mon_on) begin
        if (pf >= 0.0 && ($realtime - pf) < 9.99) runts_pci++;
        pr = $realtime;
    end
    always @(negedge pci_clk_o[0]) if (mon_on && pr >= 0.0) begin
        if (($realtime - pr) < 9.99 || ($realtime - pr) > 10.01) runts_pci++;
        pf = $realtime;
    end
    always @(posedge aux_clk_o[0]) if (mon_on) begin
        if (af >= 0.0 && ($realtime - af) < 19.99) runts_aux++;
        ar = $realtime;
    end
    always @(negedge aux_clk_o[0]) if (mon_on && ar >= 0.0) begin
        if (($realtime - ar) < 19.99 || ($realtime - ar) > 20.01) runts_aux++;
        af = $realtime;
    end

    task automatic check(input bit ok, input string req, input logic [15:0] act,
                         input logic [15:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // vector: {pwrdn_n, cpu_halt_n, pci_halt_n, cfg_en[12:0], expected toggling mask[12:0]}
    localparam int NV = 9;
    localparam logic [28:0] VEC [NV] = '{
        {3'b111, 13'h1FFF, 13'h1FFF},
        {3'b101, 13'h1FFF, 13'h1FFE},
        {3'b110, 13'h1FFF, 13'h1E07},
        {3'b100, 13'h1FFF, 13'h1E06},
        {3'b011, 13'h1FFF, 13'h0000},
        {3'b001, 13'h1FFF, 13'h0000},
        {3'b111, 13'h0AAA, 13'h0AAA},
        {3'b100, 13'h1555, 13'h1404},
        {3'b111, 13'h1FFF, 13'h1FFF}
    };

    initial begin : watchdog
        #200_000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        int snap [NOUT];
        logic [NOUT-1:0] act;
        bit ok;
        #0 rst_n = 1'b0;
        // R1: outputs low throughout reset
        ok = 1'b1;
        for (int k = 0; k < 12; k++) begin
            #3;
            if (obs !== '0) ok = 1'b0;
        end
        check(ok, "R1 reset outputs", 16'(obs), 16'h0);
        @(posedge clk_cpu); #1 rst_n = 1'b1;
        repeat (6) @(posedge clk_cpu);
        mon_on = 1'b1;

        // table walk: R4 R5 R6 R7
        for (int v = 0; v < NV; v++) begin
            @(posedge clk_cpu); #1;
            {pwrdn_n, cpu_halt_n, pci_halt_n} = VEC[v][28:26];
            cfg_en = VEC[v][25:13];
            repeat (10) @(posedge clk_cpu);
            #2;
            for (int g = 0; g < NOUT; g++) snap[g] = rise_cnt[g];
            repeat (8) @(posedge clk_cpu);
            #2;
            for (int g = 0; g < NOUT; g++) act[g] = (rise_cnt[g] > snap[g]);
            check(act == VEC[v][12:0], $sformatf("R4/R5/R6/R7 vector %0d", v),
                  16'(act), 16'(VEC[v][12:0]));
        end
        repeat (10) @(posedge clk_cpu);

        // R4: exact power-down entry
        @(posedge clk_cpu); #1 pwrdn_n = 1'b0;
        repeat (4) @(posedge clk_cpu); #2;
        check(cpu_clk_o == 1'b1, "R4 full high phase at commit edge", 16'(cpu_clk_o), 16'h1);
        check(cpuf_clk_o == 1'b1, "R4 cpuf full high phase at commit", 16'(cpuf_clk_o), 16'h1);
        @(posedge clk_cpu); #2;
        check(cpu_clk_o == 1'b0, "R4 cpu low after commit", 16'(cpu_clk_o), 16'h0);
        check(cpuf_clk_o == 1'b0, "R4 cpuf low after commit", 16'(cpuf_clk_o), 16'h0);
        repeat (6) @(posedge clk_cpu); #2;
        check(obs == '0, "R4 all outputs low in power-down", 16'(obs), 16'h0);

        // R9: exact restart
        @(posedge clk_cpu); #1 pwrdn_n = 1'b1;
        repeat (3) @(posedge clk_cpu); #2;
        check(cpu_clk_o == 1'b0, "R9 still low after E3", 16'(cpu_clk_o), 16'h0);
        @(posedge clk_cpu); #2;
        check(cpu_clk_o == 1'b1, "R9 rises at E4", 16'(cpu_clk_o), 16'h1);
        repeat (8) @(posedge clk_cpu);

        // R3: one-cycle pulse ignored
        @(posedge clk_cpu); #1 pwrdn_n = 1'b0;
        @(posedge clk_cpu); #1 pwrdn_n = 1'b1;
        ok = 1'b1;
        for (int k = 0; k < 6; k++) begin
            @(posedge clk_cpu); #2;
            if (cpu_clk_o !== 1'b1) ok = 1'b0;
        end
        check(ok, "R3 one-cycle power-down pulse ignored", 16'(ok), 16'h1);
        repeat (4) @(posedge clk_cpu);

        // R3: two-cycle pulse stops for exactly one cycle
        @(posedge clk_cpu); #1 pwrdn_n = 1'b0;
        repeat (2) @(posedge clk_cpu); #1 pwrdn_n = 1'b1;
        repeat (2) @(posedge clk_cpu); #2;
        check(cpu_clk_o == 1'b1, "R3 two-cycle pulse high at E4", 16'(cpu_clk_o), 16'h1);
        @(posedge clk_cpu); #2;
        check(cpu_clk_o == 1'b0, "R3 two-cycle pulse low at E5", 16'(cpu_clk_o), 16'h0);
        @(posedge clk_cpu); #2;
        check(cpu_clk_o == 1'b1, "R3 two-cycle pulse back at E6", 16'(cpu_clk_o), 16'h1);
        repeat (6) @(posedge clk_cpu);

        // R2 / R5: CPU halt latency through the synchronizer
        @(posedge clk_cpu); #1 cpu_halt_n = 1'b0;
        repeat (2) @(posedge clk_cpu); #2;
        check(cpu_clk_o == 1'b1, "R2 cpu still high after E2", 16'(cpu_clk_o), 16'h1);
        @(posedge clk_cpu); #2;
        check(cpu_clk_o == 1'b0, "R2 cpu halted after E3", 16'(cpu_clk_o), 16'h0);
        check(cpuf_clk_o == 1'b1, "R5 cpuf keeps running", 16'(cpuf_clk_o), 16'h1);
        @(posedge clk_cpu); #1 cpu_halt_n = 1'b1;
        repeat (10) @(posedge clk_cpu);

        mon_on = 1'b0;
        check(runts_cpu == 0, "R8 cpu runts", 16'(runts_cpu), 16'h0);
        check(runts_cpuf == 0, "R8 cpuf runts", 16'(runts_cpuf), 16'h0);
        check(runts_pci == 0, "R8 pci runts", 16'(runts_pci), 16'h0);
        check(runts_aux == 0, "R8 aux runts", 16'(runts_aux), 16'h0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule